// File: doc/BRIEF.md
# External Pin Event Flag Register

This block watches eight external input pins and records edge events on them in one CPU-visible 8-bit flag register. The upper five pins are keypad lines that only ever report a falling edge. The lower three are general interrupt lines, and each one has its own select input that picks either the rising or the falling edge. Each pin also has an enable input. A flag is set only when its pin is enabled and the qualifying edge arrives. Every raw pin first passes through a multi-flop synchronizer. The edge is then found by comparing the synchronized value with the synchronized value of the cycle before.

Flags are sticky. Software reads the register at its decoded address. To clear flags it writes the same address: every data bit written as 0 clears its flag, and every bit written as 1 leaves its flag alone. A single interrupt request output stays high while any flag is set. If an edge event and a clearing write hit the same flag in the same cycle, the event wins, so no event is lost. The enable inputs, the edge-select inputs and the CPU's vectoring logic belong to neighbouring blocks.

Top module: `ext_event_flags`

## Requirements
- R1: After reset all eight flags read 0 and `int_req` is 0.
- R2: Keypad pin `key_pins[i]` is mapped to flag bit 3+i. With `key_en[i]`=1, a falling edge on that pin sets the flag. The flag becomes visible at the third rising clock edge after the pin change is first sampled: two synchronizer flops, then the flag register.
- R3: A rising edge on a keypad pin never sets its flag.
- R4: A pin whose enable bit is 0 never sets its flag, whatever edges it sees.
- R5: Interrupt pin `irq_pins[j]` is mapped to flag bit j. With `irq_en[j]`=1, its flag is set by a rising edge when `irq_rise_sel[j]`=1, or by a falling edge when `irq_rise_sel[j]`=0. The other edge is ignored.
- R6: A write with `bus_addr`=0x1E clears, at the next clock edge, every flag whose `bus_wdata` bit is 0. Flags whose data bit is 1 are left unchanged.
- R7: A write to any other address changes no flag.
- R8: When a flag's set event and a clearing write for that flag fall in the same cycle, the flag ends up set.
- R9: `int_req` is high exactly when at least one flag is set.
- R10: When `bus_rd`=1 and `bus_addr`=0x1E, `bus_rdata` shows the flags: keypad flags in bits 7..3 and interrupt flags in bits 2..0. In every other case `bus_rdata` is 0.
- R11: A set flag stays set until a clearing write for it arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_pins | input | 5 | Raw keypad pins, idle high |
| irq_pins | input | 3 | Raw interrupt pins, idle high |
| key_en | input | 5 | Per-pin enable for the keypad flags |
| irq_en | input | 3 | Per-pin enable for the interrupt flags |
| irq_rise_sel | input | 3 | 1 selects the rising edge, 0 selects the falling edge |
| bus_addr | input | 8 | CPU address |
| bus_wr | input | 1 | CPU write strobe |
| bus_rd | input | 1 | CPU read strobe |
| bus_wdata | input | 8 | CPU write data; a 0 bit clears that flag |
| bus_rdata | output | 8 | CPU read data |
| int_req | output | 1 | OR of all flags |

## Verification
The bench builds the block with its default parameters: five keypad pins, three interrupt pins, two synchronizer stages, idle-high pins and the register at 0x1E. This gives a fixed three-edge path from pin to flag. The bench can therefore sample exactly one cycle before and at the edge where a flag rises, and it can land a clearing write on the very edge where an event sets the same flag. With both edge-select values present on the interrupt pins, both edge polarities and the ignored opposite edge are checked within one run.

// File: rtl/evf_pkg.sv
package evf_pkg;

  // Edge qualification: rise_sel=1 looks for 0->1, rise_sel=0 looks for 1->0.
  function automatic logic edge_seen(input logic prev, input logic cur, input logic rise_sel);
    if (rise_sel) return (!prev) && cur;
    else          return prev && (!cur);
  endfunction

  // Next flag value: a set event beats a clear request.
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/evf_pin_sync.sv
module evf_pin_sync #(
  parameter int WIDTH = 8,
  parameter int STAGES = 2,
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] synced
);
  localparam logic [WIDTH-1:0] RST_VEC = {WIDTH{IDLE_LEVEL}};

  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RST_VEC;
          else        chain[0] <= raw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VEC;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign synced = chain[STAGES-1];
endmodule

// File: rtl/evf_edge_detect.sv
module evf_edge_detect
  import evf_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] synced,
  input  logic [WIDTH-1:0] rise_sel,
  output logic [WIDTH-1:0] hit
);
  localparam logic [WIDTH-1:0] RST_VEC = {WIDTH{IDLE_LEVEL}};

  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VEC;
    else        prev_q <= synced;
  end

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      assign hit[b] = edge_seen(prev_q[b], synced[b], rise_sel[b]);
    end
  endgenerate
endmodule

// File: rtl/evf_flag_bank.sv
module evf_flag_bank
  import evf_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_vec,
  input  logic [WIDTH-1:0] clr_vec,
  output logic [WIDTH-1:0] flags_q
);
  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q[b] <= 1'b0;
        else        flags_q[b] <= flag_next(flags_q[b], set_vec[b], clr_vec[b]);
      end
    end
  endgenerate
endmodule

// File: rtl/ext_event_flags.sv
module ext_event_flags #(
  parameter int NUM_KEY = 5,
  parameter int NUM_IRQ = 3,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h1E,
  parameter int SYNC_STAGES = 2,
  parameter logic IDLE_LEVEL = 1'b1,
  localparam int DATA_W = NUM_KEY + NUM_IRQ
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_KEY-1:0] key_pins,
  input  logic [NUM_IRQ-1:0] irq_pins,
  input  logic [NUM_KEY-1:0] key_en,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic [NUM_IRQ-1:0] irq_rise_sel,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               int_req
);
  // Named internal events, brought out for the checker.
  logic [DATA_W-1:0] pins_all;
  logic [DATA_W-1:0] pins_sync;
  logic [DATA_W-1:0] sel_all;
  logic [DATA_W-1:0] en_all;
  logic [DATA_W-1:0] edge_hit;
  logic [DATA_W-1:0] set_vec;
  logic [DATA_W-1:0] clr_vec;
  logic [DATA_W-1:0] flags_q;
  logic              addr_hit;
  logic              wr_hit;

  assign pins_all = {key_pins, irq_pins};
  // Keypad lines are fixed to falling-edge detection.
  assign sel_all  = {{NUM_KEY{1'b0}}, irq_rise_sel};
  assign en_all   = {key_en, irq_en};

  evf_pin_sync #(
    .WIDTH(DATA_W), .STAGES(SYNC_STAGES), .IDLE_LEVEL(IDLE_LEVEL)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pins_all), .synced(pins_sync)
  );

  evf_edge_detect #(
    .WIDTH(DATA_W), .IDLE_LEVEL(IDLE_LEVEL)
  ) u_edge (
    .clk(clk), .rst_n(rst_n), .synced(pins_sync), .rise_sel(sel_all), .hit(edge_hit)
  );

  assign set_vec  = edge_hit & en_all;
  assign addr_hit = (bus_addr == REG_ADDR);
  assign wr_hit   = bus_wr && addr_hit;
  assign clr_vec  = wr_hit ? ~bus_wdata : '0;

  evf_flag_bank #(
    .WIDTH(DATA_W)
  ) u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .flags_q(flags_q)
  );

  assign bus_rdata = (bus_rd && addr_hit) ? flags_q : '0;
  assign int_req   = |flags_q;
endmodule

// File: rtl/evf_checker.sv
module evf_checker #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h1E
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              int_req,
  input logic [DATA_W-1:0] flags_q,
  input logic [DATA_W-1:0] set_vec,
  input logic [DATA_W-1:0] en_all
);
  logic chk_wr;
  assign chk_wr = bus_wr && (bus_addr == REG_ADDR);

  genvar b;
  generate
    for (b = 0; b < DATA_W; b++) begin : g_bit
      AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[b] && !(chk_wr && !bus_wdata[b])) |=> flags_q[b]); // R11
      AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_wr && !bus_wdata[b] && !set_vec[b]) |=> !flags_q[b]); // R6
      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[b] |=> flags_q[b]); // R8
      AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_all[b] && !flags_q[b]) |=> !flags_q[b]); // R4
    end
  endgenerate

  AST_REQ_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_req) |-> $past(|set_vec)); // R9
  AST_READ_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && (bus_addr == REG_ADDR)) |-> (bus_rdata == '0)); // R10
endmodule

bind ext_event_flags evf_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .int_req(int_req),
  .flags_q(flags_q), .set_vec(set_vec), .en_all(en_all)
);

// File: tb/sim_ext_event_flags.sv
`timescale 1ns/1ps
module sim_ext_event_flags;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] key_pins = 5'h1F;
  logic [2:0] irq_pins = 3'h7;
  logic [4:0] key_en = 5'h00;
  logic [2:0] irq_en = 3'h0;
  logic [2:0] irq_rise_sel = 3'h0;
  logic [7:0] bus_addr = 8'h00;
  logic bus_wr = 1'b0;
  logic bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'hFF;
  logic [7:0] bus_rdata;
  logic int_req;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ext_event_flags u0 (
    .clk(clk), .rst_n(rst_n), .key_pins(key_pins), .irq_pins(irq_pins),
    .key_en(key_en), .irq_en(irq_en), .irq_rise_sel(irq_rise_sel),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .int_req(int_req)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Advance n rising edges, then settle at the following falling edge.
  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic read_reg(input logic [7:0] addr, output logic [7:0] val);
    bus_addr = addr; bus_rd = 1'b1;
    #1 val = bus_rdata;
    bus_rd = 1'b0; bus_addr = 8'h00;
  endtask

  task automatic write_reg(input logic [7:0] addr, input logic [7:0] data);
    bus_addr = addr; bus_wdata = data; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 8'hFF; bus_addr = 8'h00;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    read_reg(8'h1E, v);
    check("R1 flags after reset", v, 8'h00);
    check("R1 int_req after reset", {7'b0, int_req}, 8'h00);
  endtask

  task automatic t_key_fall();
    logic [7:0] v;
    key_pins[0] = 1'b0;          // falling edge on keypad pin 0 -> bit 3
    cycles(2);
    read_reg(8'h1E, v);
    check("R2 not yet set after two edges", v, 8'h00);
    cycles(1);
    read_reg(8'h1E, v);
    check("R2 keypad falling edge sets bit 3", v, 8'h08);
    check("R9 int_req with one flag", {7'b0, int_req}, 8'h01);
    read_reg(8'h1F, v);
    check("R10 read at other address is zero", v, 8'h00);
    check("R10 idle rdata is zero", bus_rdata, 8'h00);
  endtask

  task automatic t_key_rise();
    logic [7:0] v;
    write_reg(8'h1E, 8'h00);
    check("R6 clear all flags", {7'b0, int_req}, 8'h00);
    key_pins[0] = 1'b1;          // rising edge must be ignored
    cycles(5);
    read_reg(8'h1E, v);
    check("R3 keypad rising edge ignored", v, 8'h00);
  endtask

  task automatic t_disabled();
    logic [7:0] v;
    key_en[2] = 1'b0; irq_en[2] = 1'b0; irq_rise_sel[2] = 1'b0;
    key_pins[2] = 1'b0; irq_pins[2] = 1'b0;
    cycles(5);
    key_pins[2] = 1'b1; irq_pins[2] = 1'b1;
    cycles(5);
    read_reg(8'h1E, v);
    check("R4 disabled pins leave flags clear", v, 8'h00);
    check("R9 int_req low with no flags", {7'b0, int_req}, 8'h00);
    key_en[2] = 1'b1; irq_en[2] = 1'b1;
  endtask

  task automatic t_irq_select();
    logic [7:0] v;
    irq_pins[0] = 1'b0;          // falling on a rising-select pin: ignored
    cycles(4);
    read_reg(8'h1E, v);
    check("R5 opposite edge ignored on rising-select pin", v, 8'h00);
    irq_pins[0] = 1'b1;          // rising -> bit 0
    cycles(3);
    read_reg(8'h1E, v);
    check("R5 rising select sets bit 0", v, 8'h01);
    irq_pins[1] = 1'b0;          // falling on a falling-select pin -> bit 1
    cycles(3);
    read_reg(8'h1E, v);
    check("R5 falling select sets bit 1", v, 8'h03);
    irq_pins[1] = 1'b1;
    key_pins[4] = 1'b0;          // keypad pin 4 -> bit 7
    cycles(3);
    read_reg(8'h1E, v);
    check("R10 bit layout, keypad 4 in bit 7", v, 8'h83);
    key_pins[4] = 1'b1;
    cycles(3);
  endtask

  task automatic t_clear();
    logic [7:0] v;
    write_reg(8'h1F, 8'h00);
    read_reg(8'h1E, v);
    check("R7 write to other address ignored", v, 8'h83);
    write_reg(8'h1E, 8'hFF);
    read_reg(8'h1E, v);
    check("R6 writing ones changes nothing", v, 8'h83);
    write_reg(8'h1E, 8'hFE);
    read_reg(8'h1E, v);
    check("R6 write zero clears only bit 0", v, 8'h82);
    cycles(40);
    read_reg(8'h1E, v);
    check("R11 flags held over idle cycles", v, 8'h82);
    check("R9 int_req held", {7'b0, int_req}, 8'h01);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    // Bit 1 is set; a new falling edge on interrupt pin 1 lands on the same
    // rising edge as a clear-everything write.
    irq_pins[1] = 1'b0;
    cycles(2);
    write_reg(8'h1E, 8'h00);
    read_reg(8'h1E, v);
    check("R8 set beats clear, others cleared", v, 8'h02);
    write_reg(8'h1E, 8'h00);
    read_reg(8'h1E, v);
    check("R6 later clear removes bit 1", v, 8'h00);
    check("R9 int_req drops with last flag", {7'b0, int_req}, 8'h00);
    irq_pins[1] = 1'b1;
    cycles(3);
  endtask

  initial begin
    key_en = 5'h1F; irq_en = 3'h7; irq_rise_sel = 3'b001;
    cycles(3);
    rst_n = 1'b1;
    cycles(3);
    t_reset();
    t_key_fall();
    t_key_rise();
    t_disabled();
    t_irq_select();
    t_clear();
    t_collide();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule